// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets logic running on one clock read and write an external asynchronous static RAM of 1M words by 4 bits. The RAM has a single bidirectional data bus. The host raises a request with a direction flag, an address and, for writes, a data nibble. The controller then runs one complete memory cycle on the RAM's active-low select, write-enable and output-enable pins. When the cycle has finished, it pulses `done`. Read data is captured into a register and stays there until the next read replaces it.

Every timing minimum of the RAM is a parameter in nanoseconds. The clock period is a parameter too. The controller rounds each minimum up to whole clock cycles, with at least one cycle per phase.

During writes, output enable stays high, so the shorter write-pulse minimum applies. After every read there is a float interval before the controller may drive the shared bus. The controller never drives the bus while the RAM's outputs could be on.

The state machine has five states:
- `ST_IDLE`: all strobes are high. An accepted request moves to `ST_RD_ACCESS` when `host_wr`=0, or to `ST_WR_PULSE` when `host_wr`=1.
- `ST_RD_ACCESS`: select and output enable are low. When the access count expires, it captures the data and moves to `ST_RD_TURN`.
- `ST_RD_TURN`: all strobes are high and the bus floats. When the float count expires, it returns to `ST_IDLE`.
- `ST_WR_PULSE`: select and write enable are low, and the data drivers are on. When the pulse count expires, it moves to `ST_WR_RECOV`.
- `ST_WR_RECOV`: the strobes are high, and the data and address are held. When the recovery count expires, it returns to `ST_IDLE`.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, the data drivers are off and `done` is 0. After reset `rdata` is 0.
- R2: A read (`host_wr`=0) accepted at a clock edge drives `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 from that edge on. The pins stay so for ceil(max(tAA,tRC,tOE)/Tclk) cycles, which is 2 with the defaults.
- R3: Read data is sampled from `mem_dq` on the edge that ends the read access phase. It appears on `rdata` from that edge and is held unchanged until the next read is sampled.
- R4: After the read access phase, all three strobes are 1 and the controller does not drive the bus for ceil(tHZ/Tclk) cycles, which is 1 with the defaults.
- R5: A write (`host_wr`=1) accepted at a clock edge drives `mem_cs_n`=0 and `mem_we_n`=0, and drives `wdata` onto `mem_dq`. This lasts for max(ceil(tWP/Tclk), ceil(tDW/Tclk)) cycles, which is 2 with the defaults.
- R6: After the write pulse, `mem_cs_n`=1 and `mem_we_n`=1 while the data and address stay driven. This lasts for max(1, ceil(tWC/Tclk) minus the pulse cycles) cycles, which is 1 with the defaults. The drivers are then released.
- R7: `done` is high for exactly one cycle, the first idle cycle after each read or write. A request presented in that cycle is accepted.
- R8: A request presented while a cycle is in progress is ignored. It causes no memory access and no change to memory contents.
- R9: `mem_oe_n` is 1 whenever the controller drives `mem_dq`, and for the cycle before the drive starts.
- R10: `mem_addr` equals the accepted address and does not change while `mem_cs_n` is 0 or the controller drives data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Request, sampled in idle cycles |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address |
| host_wdata | input | 4 | Write data |
| rdata | output | 4 | Last captured read data |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 20 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq | inout | 4 | Shared RAM data bus |

## Verification
A wrong state or a miscounted phase shows at the RAM pins in the very next cycle: a strobe pattern that is too short, too long or out of order. A fault that sends the machine into a wrong branch shows as write enable low during a read, or as data driven while output enable is low. Any of these is reported within one clock. A capture on the wrong edge or a lost hold shows on `rdata` in the same cycle. A missing or doubled `done` is seen in the first idle cycle. A request wrongly accepted while busy shows up at once as unexpected strobes, and later as corrupted data read back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_RECOV
    } ctrl_state_e;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == '0);

    AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R2

endmodule

// File: rtl/sram_cmd_reg.sv
`timescale 1ns/1ps
module sram_cmd_reg #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end
endmodule

// File: rtl/sram_dq_port.sv
`timescale 1ns/1ps
module sram_dq_port #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] dq
);
    assign dq = drv_en ? wdata : {DATA_W{1'bz}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= dq;
        end
    end

    AST_NO_CAPTURE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !drv_en); // R9
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 4,
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned T_AA_NS       = 10,
    parameter int unsigned T_RC_NS       = 10,
    parameter int unsigned T_OE_NS       = 5,
    parameter int unsigned T_HZ_NS       = 5,
    parameter int unsigned T_WP_NS       = 7,
    parameter int unsigned T_DW_NS       = 5,
    parameter int unsigned T_WC_NS       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int unsigned RD_CYC    = umax(umax(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                                  ns_to_cycles(T_RC_NS, CLK_PERIOD_NS)),
                                             ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
    localparam int unsigned TURN_CYC  = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int unsigned PULSE_CYC = umax(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                             ns_to_cycles(T_DW_NS, CLK_PERIOD_NS));
    localparam int unsigned WC_CYC    = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned RECOV_CYC = (WC_CYC > PULSE_CYC) ? (WC_CYC - PULSE_CYC) : 1;
    localparam int unsigned MAX_CYC   = umax(umax(RD_CYC, TURN_CYC), umax(PULSE_CYC, RECOV_CYC));
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    ctrl_state_e      state_q, state_d;
    logic             tmr_load, tmr_last, accept, capture;
    logic [CNT_W-1:0] tmr_val;
    logic             drv_en_q;
    logic [DATA_W-1:0] wdata_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
    );

    sram_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .accept(accept), .in_addr(host_addr),
        .in_wdata(host_wdata), .addr_q(mem_addr), .wdata_q(wdata_q)
    );

    sram_dq_port #(.DATA_W(DATA_W)) u_dq (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en_q), .wdata(wdata_q),
        .capture(capture), .rdata(rdata), .dq(mem_dq)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state, timer loads, accept and capture strobes
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (host_wr) begin
                        state_d = ST_WR_PULSE;
                        tmr_val = CNT_W'(PULSE_CYC);
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_last) begin
                    capture  = 1'b1;
                    state_d  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC);
                end
            end
            ST_RD_TURN: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    state_d  = ST_WR_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RECOV_CYC);
                end
            end
            ST_WR_RECOV: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            drv_en_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            mem_cs_n <= !(state_d == ST_RD_ACCESS || state_d == ST_WR_PULSE);
            mem_we_n <= !(state_d == ST_WR_PULSE);
            mem_oe_n <= !(state_d == ST_RD_ACCESS);
            drv_en_q <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_RECOV);
            done     <= (state_q == ST_RD_TURN || state_q == ST_WR_RECOV) && (state_d == ST_IDLE);
        end
    end

    AST_WE_ONLY_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n); // R5
    AST_OE_HIGH_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_q |-> mem_oe_n); // R9
    AST_DRIVE_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_q) |-> $past(mem_oe_n)); // R9
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (!mem_oe_n && mem_we_n && !mem_cs_n)); // R3

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

    localparam int PER = 5;
    function automatic int cyc(input int t);
        int c;
        c = (t + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int RD_N    = mx(mx(cyc(10), cyc(10)), cyc(5));
    localparam int TURN_N  = cyc(5);
    localparam int PULSE_N = mx(cyc(7), cyc(5));
    localparam int RECOV_N = (cyc(10) > PULSE_N) ? cyc(10) - PULSE_N : 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [19:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic [3:0]  rdata;
    logic        done;
    logic [19:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n;
    wire  [3:0]  mem_dq;

    always #2.5 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .rdata(rdata), .done(done),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    // Behavioural RAM
    logic [3:0] store [int];
    function automatic logic [3:0] peek(input logic [19:0] a);
        if (store.exists(int'(a))) return store[int'(a)];
        return a[3:0] ^ a[7:4];
    endfunction
    logic [3:0] ram_out;
    wire ram_drv = !mem_cs_n && mem_we_n && !mem_oe_n;
    wire wr_act  = !mem_cs_n && !mem_we_n;
    always @(mem_addr or mem_cs_n or mem_we_n or mem_oe_n) ram_out = peek(mem_addr);
    assign mem_dq = ram_drv ? ram_out : 4'bzzzz;
    always @(negedge wr_act) store[int'(mem_addr)] = mem_dq;

    // Reference model
    typedef struct {
        bit cs_n, we_n, oe_n, drv, upd;
        bit [19:0] addr;
        bit [3:0]  wd, rv;
        string tag;
    } exp_t;
    exp_t q[$];
    logic [3:0] ref_mem [int];
    logic [3:0] exp_rdata = '0;
    bit pend_done = 0;
    string idle_tag = "R1";
    int tests = 0, fails = 0;
    bit finished = 0;

    function automatic logic [3:0] ref_peek(input logic [19:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return a[3:0] ^ a[7:4];
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_op(input bit w, input logic [19:0] a, input logic [3:0] d);
        exp_t e;
        if (!w) begin
            for (int i = 0; i < RD_N; i++) begin
                e = '{cs_n:0, we_n:1, oe_n:0, drv:0, upd:0, addr:a, wd:0, rv:0, tag:"R2"};
                q.push_back(e);
            end
            for (int i = 0; i < TURN_N; i++) begin
                e = '{cs_n:1, we_n:1, oe_n:1, drv:0, upd:(i == 0), addr:a, wd:0, rv:ref_peek(a), tag:"R4"};
                q.push_back(e);
            end
        end else begin
            for (int i = 0; i < PULSE_N; i++) begin
                e = '{cs_n:0, we_n:0, oe_n:1, drv:1, upd:0, addr:a, wd:d, rv:0, tag:"R5"};
                q.push_back(e);
            end
            for (int i = 0; i < RECOV_N; i++) begin
                e = '{cs_n:1, we_n:1, oe_n:1, drv:1, upd:0, addr:a, wd:d, rv:0, tag:"R6"};
                q.push_back(e);
            end
            ref_mem[int'(a)] = d;
        end
    endtask

    task automatic step(input bit r, input bit w, input logic [19:0] a, input logic [3:0] d);
        bit idle_now, exp_done;
        exp_t e;
        @(negedge clk);
        idle_now  = (q.size() == 0);
        exp_done  = pend_done;
        pend_done = 0;
        if (idle_now) begin
            chk(idle_tag, "cs_n", 32'(mem_cs_n), 1);
            chk(idle_tag, "we_n", 32'(mem_we_n), 1);
            chk(idle_tag, "oe_n", 32'(mem_oe_n), 1);
        end else begin
            e = q.pop_front();
            if (e.upd) exp_rdata = e.rv;
            if (q.size() == 0) pend_done = 1;
            chk(e.tag, "cs_n", 32'(mem_cs_n), 32'(e.cs_n));
            chk(e.tag, "we_n", 32'(mem_we_n), 32'(e.we_n));
            chk(e.drv ? "R9" : e.tag, "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
            if (!e.cs_n || e.drv) chk("R10", "addr", 32'(mem_addr), 32'(e.addr));
            if (e.drv) chk(e.tag, "dq", 32'(mem_dq), 32'(e.wd));
        end
        chk("R7", "done", 32'(done), 32'(exp_done));
        chk("R3", "rdata", 32'(rdata), 32'(exp_rdata));
        host_req   <= r;
        host_wr    <= w;
        host_addr  <= a;
        host_wdata <= d;
        if (r && idle_now) begin
            idle_tag = "R1";
            push_op(w, a, d);
        end else if (r) begin
            idle_tag = "R8";   // R8: request while busy must be ignored
        end
    endtask

    task automatic op(input bit w, input logic [19:0] a, input logic [3:0] d);
        while (q.size() != 0) step(0, 0, '0, '0);
        step(1, w, a, d);
    endtask

    initial begin
        logic [19:0] lf;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1", "cs_n", 32'(mem_cs_n), 1);
        chk("R1", "we_n", 32'(mem_we_n), 1);
        chk("R1", "oe_n", 32'(mem_oe_n), 1);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "rdata", 32'(rdata), 0);
        rst_n = 1'b1;
        repeat (2) step(0, 0, '0, '0);
        // boundary addresses and basic write/read
        op(1, 20'h00000, 4'h3);
        op(1, 20'hFFFFF, 4'hC);
        op(1, 20'h12345, 4'hA);
        op(0, 20'h00000, 4'h0);
        op(0, 20'hFFFFF, 4'h0);
        op(0, 20'h12345, 4'h0);
        op(0, 20'h0ABCD, 4'h0);          // never written
        // R8: request during busy write is ignored, memory unchanged
        op(1, 20'h00055, 4'h6);
        step(1, 1, 20'h00055, 4'h9);
        step(1, 0, 20'h00077, 4'h0);
        repeat (6) step(0, 0, '0, '0);
        op(0, 20'h00055, 4'h0);
        // R3: rdata held across a following write
        op(1, 20'h00200, 4'hF);
        repeat (3) step(0, 0, '0, '0);
        // mixed traffic, requests issued in the done cycle (R7)
        lf = 20'h5A5A5;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[18:0], lf[19] ^ lf[16]};
            op(lf[0], {16'h0, lf[7:4]} ^ 20'hF0F00, lf[11:8]);
        end
        repeat (8) step(0, 0, '0, '0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog R7: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule